// File: doc/BRIEF.md
# Audio Codec Register Setup and Volume Sequencer

This block is the control layer above an audio codec frame controller. After a system reset it drives the codec reset line low for a fixed number of clock cycles and then releases it. Once the codec reports ready, it issues a fixed list of register writes. Each write is one address/data command, and the framer sends one command in the command slots of one frame. The list includes the variable-rate enable and the DAC and ADC sample-rate registers, both set to 0x0FA0. When the list is done, the block enables the PCM playback and record slots.

From then on it watches two groups of switches: speaker mute plus attenuation, and microphone mute plus gain. The switches are synchronized and filtered. Whenever a filtered setting differs from the word last written for it, the block sends a new volume register write. Each command is held on `cmd_valid`/`cmd_addr`/`cmd_data` until the framer pulses `cmd_taken` to report that the command slot went out. This gives at most one command per frame.

States: `S_HOLD` (codec reset held) → `S_WAIT_RDY` when the hold count expires → `S_INIT` when `codec_ready` is high → `S_IDLE` on the acknowledge of the last setup write. `S_IDLE` → `S_SPK` when the speaker word changed, otherwise → `S_MIC` when the microphone word changed. `S_SPK`/`S_MIC` → `S_IDLE` on acknowledge.

Top module: `codec_init_seq`

## Requirements
- R1: `codec_rst_n` is low during reset and for exactly HOLD_CYCLES rising clock edges after `rst_n` is released. It then stays high until the next reset.
- R2: No command is presented while `codec_rst_n` is low or before `codec_ready` has been seen high after the hold. `codec_ready` has no effect during the hold.
- R3: The setup writes go out in this order as {address, data}: {0x2A, 0x0001}, {0x2C, 0x0FA0}, {0x32, 0x0FA0}, {0x1C, 0x0000}.
- R4: A presented command keeps its address and data until `cmd_taken` is seen with `cmd_valid` high. Each such acknowledge retires exactly one command. A `cmd_taken` pulse while `cmd_valid` is low has no effect.
- R5: After the setup list, the speaker volume word is written once and then the microphone word is written once, whatever the switch values are.
- R6: A volume word has the mute switch in bit 15 and the ATT_W-bit switch value in bits ATT_W-1:0; all other bits are zero. The speaker word goes to address 0x02 and the microphone word goes to address 0x0E.
- R7: A volume word is resent only when its filtered switch value differs from the word last acknowledged. When both groups differ, speaker goes first.
- R8: The word is captured when the command is presented. If the switches change while that command waits, the old word is sent first and the new word follows in a second command.
- R9: `pcm_en` is low until the last setup write is acknowledged. It is high from then on until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_ready | input | 1 | Codec reports it is ready for commands |
| cmd_taken | input | 1 | Framer pulse: the command slot of the current frame was sent |
| spk_mute | input | 1 | Speaker mute switch |
| spk_att | input | ATT_W | Speaker attenuation switches |
| mic_mute | input | 1 | Microphone mute switch |
| mic_gain | input | ATT_W | Microphone gain switches |
| codec_rst_n | output | 1 | Active-low reset to the codec |
| cmd_valid | output | 1 | A register write command is presented |
| cmd_addr | output | 7 | Register address of the command |
| cmd_data | output | 16 | Register write data of the command |
| pcm_en | output | 1 | Enable the PCM playback/record slot tags |

## Verification
The hardest case to reach is a switch change that lands after a volume command has been presented but before the framer acknowledges it. Only a captured-versus-live mismatch can show that case. The bench models the framer with random acknowledge delays, so it can wait until `cmd_valid` is up and flip the speaker switches in that window. It then expects two writes in a row, first the old word and then the new one. Stray `cmd_taken` pulses while nothing is pending are also sent, before readiness and in idle, to show that no command is skipped or created.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam int INIT_LEN = 4;
    localparam int IDX_W    = (INIT_LEN > 1) ? $clog2(INIT_LEN) : 1;

    typedef enum logic [2:0] {
        S_HOLD,
        S_WAIT_RDY,
        S_INIT,
        S_SPK,
        S_MIC,
        S_IDLE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_cmd_t;

    // Setup list; order matters: rate enable precedes the rate values.
    function automatic reg_cmd_t setup_cmd(input logic [IDX_W-1:0] i);
        reg_cmd_t c;
        unique case (i)
            IDX_W'(0): begin c.addr = 7'h2A; c.data = 16'h0001; end
            IDX_W'(1): begin c.addr = 7'h2C; c.data = 16'h0FA0; end
            IDX_W'(2): begin c.addr = 7'h32; c.data = 16'h0FA0; end
            default:   begin c.addr = 7'h1C; c.data = 16'h0000; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rst_hold_ctr.sv
module rst_hold_ctr #(
    parameter int HOLD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold_done
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CNT_W'(HOLD_CYCLES))
            cnt <= cnt + 1'b1;
    end

    assign hold_done = (cnt == CNT_W'(HOLD_CYCLES));

    // R1: once released the codec reset stays released
    a_r1_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |=> hold_done);

endmodule

// File: rtl/sw_filter.sv
module sw_filter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    logic [W-1:0] s1, s2, s3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= '0;
            s2    <= '0;
            s3    <= '0;
            clean <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
            if (s2 == s3)
                clean <= s3;
        end
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import codec_init_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SPK_ADDR = 7'h02,
    parameter logic [ADDR_W-1:0] MIC_ADDR = 7'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_done,
    input  logic              codec_ready,
    input  logic              cmd_taken,
    input  logic [DATA_W-1:0] spk_word,
    input  logic [DATA_W-1:0] mic_word,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              pcm_en
);
    seq_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] pend;
    logic [DATA_W-1:0] spk_last, mic_last;
    logic              spk_ok, mic_ok;
    logic              spk_chg, mic_chg, last_idx;
    reg_cmd_t          rom_cmd;

    assign spk_chg  = !spk_ok || (spk_word != spk_last);
    assign mic_chg  = !mic_ok || (mic_word != mic_last);
    assign last_idx = (idx == IDX_W'(INIT_LEN - 1));
    assign rom_cmd  = setup_cmd(idx);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_HOLD:     if (hold_done)   state_nx = S_WAIT_RDY;
            S_WAIT_RDY: if (codec_ready) state_nx = S_INIT;
            S_INIT:     if (cmd_taken && last_idx) state_nx = S_IDLE;
            S_SPK:      if (cmd_taken) state_nx = S_IDLE;
            S_MIC:      if (cmd_taken) state_nx = S_IDLE;
            S_IDLE: begin
                if (spk_chg)      state_nx = S_SPK;
                else if (mic_chg) state_nx = S_MIC;
            end
            default:    state_nx = S_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HOLD;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            pend     <= '0;
            spk_last <= '0;
            mic_last <= '0;
            spk_ok   <= 1'b0;
            mic_ok   <= 1'b0;
            pcm_en   <= 1'b0;
        end else begin
            unique case (state)
                S_INIT: if (cmd_taken) begin
                    idx <= idx + 1'b1;
                    if (last_idx) pcm_en <= 1'b1;
                end
                S_IDLE: begin
                    if (spk_chg)      pend <= spk_word;
                    else if (mic_chg) pend <= mic_word;
                end
                S_SPK: if (cmd_taken) begin
                    spk_last <= pend;
                    spk_ok   <= 1'b1;
                end
                S_MIC: if (cmd_taken) begin
                    mic_last <= pend;
                    mic_ok   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_addr  = '0;
        cmd_data  = '0;
        unique case (state)
            S_INIT: begin
                cmd_valid = 1'b1;
                cmd_addr  = rom_cmd.addr;
                cmd_data  = rom_cmd.data;
            end
            S_SPK: begin
                cmd_valid = 1'b1;
                cmd_addr  = SPK_ADDR;
                cmd_data  = pend;
            end
            S_MIC: begin
                cmd_valid = 1'b1;
                cmd_addr  = MIC_ADDR;
                cmd_data  = pend;
            end
            default: ;
        endcase
    end

    // R2: nothing presented while the codec is held in reset
    a_r2_no_cmd_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> hold_done);

    // R4: a waiting command keeps its content
    a_r4_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_taken) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

    // R9: PCM enable never drops once set
    a_r9_pcm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_en |=> pcm_en);

    // R9: PCM enable only after the codec reset is released
    a_r9_pcm_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_en |-> hold_done);

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int ATT_W       = 5,
    parameter int HOLD_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_ready,
    input  logic              cmd_taken,
    input  logic              spk_mute,
    input  logic [ATT_W-1:0]  spk_att,
    input  logic              mic_mute,
    input  logic [ATT_W-1:0]  mic_gain,
    output logic              codec_rst_n,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              pcm_en
);
    localparam int GRP_W = ATT_W + 1;
    localparam int PAD_W = DATA_W - 1 - ATT_W;
    localparam logic [ADDR_W-1:0] SPK_A = 7'h02;
    localparam logic [ADDR_W-1:0] MIC_A = 7'h0E;

    logic              hold_done;
    logic [2*GRP_W-1:0] sw_clean;
    logic [DATA_W-1:0] spk_word, mic_word;

    rst_hold_ctr #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .hold_done(hold_done)
    );

    sw_filter #(.W(2*GRP_W)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .raw({spk_mute, spk_att, mic_mute, mic_gain}),
        .clean(sw_clean)
    );

    assign spk_word = {sw_clean[2*GRP_W-1], {PAD_W{1'b0}}, sw_clean[GRP_W+ATT_W-1:GRP_W]};
    assign mic_word = {sw_clean[GRP_W-1],   {PAD_W{1'b0}}, sw_clean[ATT_W-1:0]};

    seq_fsm #(.SPK_ADDR(SPK_A), .MIC_ADDR(MIC_A)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .hold_done(hold_done), .codec_ready(codec_ready), .cmd_taken(cmd_taken),
        .spk_word(spk_word), .mic_word(mic_word),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .pcm_en(pcm_en)
    );

    assign codec_rst_n = hold_done;

    // R6: volume words carry zeros between mute bit and level field
    a_r6_vol_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_addr == SPK_A || cmd_addr == MIC_A))
            |-> (cmd_data[DATA_W-2:ATT_W] == '0));

endmodule

// File: tb/sim_codec_init_seq.sv
`timescale 1ns/1ps
module sim_codec_init_seq;
    localparam int ATT_W = 5;
    localparam int HOLD  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic codec_ready = 1'b0;
    logic cmd_taken = 1'b0;
    logic spk_mute = 1'b0, mic_mute = 1'b0;
    logic [ATT_W-1:0] spk_att = '0, mic_gain = '0;
    logic codec_rst_n, cmd_valid, pcm_en;
    logic [6:0]  cmd_addr;
    logic [15:0] cmd_data;

    int n_chk = 0, n_bad = 0;
    logic [15:0] spk_sent, mic_sent;

    always #2 clk = ~clk;

    codec_init_seq #(.ATT_W(ATT_W), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .codec_ready(codec_ready), .cmd_taken(cmd_taken),
        .spk_mute(spk_mute), .spk_att(spk_att), .mic_mute(mic_mute), .mic_gain(mic_gain),
        .codec_rst_n(codec_rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .pcm_en(pcm_en)
    );

    function automatic logic [15:0] vol(input logic m, input logic [ATT_W-1:0] a);
        return {m, {(15-ATT_W){1'b0}}, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // framer model: wait for a command, compare it, acknowledge after a random delay
    task automatic serve(input string req, input logic [6:0] ea, input logic [15:0] ed);
        int t = 0;
        @(negedge clk);
        while (!cmd_valid && t < 200) begin @(negedge clk); t++; end
        check({req, " valid"}, 32'(cmd_valid), 32'd1);
        check({req, " addr"}, 32'(cmd_addr), 32'(ea));
        check({req, " data"}, 32'(cmd_data), 32'(ed));
        repeat ($urandom_range(0, 6)) @(negedge clk);
        cmd_taken = 1'b1;
        @(negedge clk);
        cmd_taken = 1'b0;
    endtask

    task automatic quiet(input string req, input int cyc);
        int seen = 0;
        repeat (cyc) begin @(negedge clk); if (cmd_valid) seen = 1; end
        check(req, 32'(seen), 32'd0);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int n;
        logic        nm, nmm;
        logic [ATT_W-1:0] na, ng;
        void'($urandom(32'd1234));
        spk_mute = 1'b1; spk_att = 5'h0A; mic_mute = 1'b0; mic_gain = 5'h13;
        repeat (4) @(negedge clk);
        check("R1 reset codec_rst_n", 32'(codec_rst_n), 32'd0);
        check("R2 reset cmd_valid", 32'(cmd_valid), 32'd0);
        check("R9 reset pcm_en", 32'(pcm_en), 32'd0);
        codec_ready = 1'b1;              // R2: ignored during hold
        rst_n = 1'b1;
        n = 0;
        while (n < HOLD + 10) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (cmd_valid) check("R2 cmd during hold", 32'd1, 32'd0);
            if (codec_rst_n) break;
        end
        check("R1 hold length", 32'(n), 32'(HOLD));
        codec_ready = 1'b0;
        // stray acknowledge before readiness (R4)
        @(negedge clk); cmd_taken = 1'b1; @(negedge clk); cmd_taken = 1'b0;
        quiet("R2 wait for ready", 20);
        check("R1 codec_rst_n stays high", 32'(codec_rst_n), 32'd1);
        codec_ready = 1'b1;
        serve("R3 setup0", 7'h2A, 16'h0001);
        serve("R3 setup1", 7'h2C, 16'h0FA0);
        serve("R3 setup2", 7'h32, 16'h0FA0);
        check("R9 pcm_en during setup", 32'(pcm_en), 32'd0);
        serve("R3 setup3", 7'h1C, 16'h0000);
        check("R9 pcm_en after setup", 32'(pcm_en), 32'd1);
        serve("R5 first speaker", 7'h02, vol(1'b1, 5'h0A));
        serve("R5 first mic", 7'h0E, vol(1'b0, 5'h13));
        spk_sent = vol(1'b1, 5'h0A); mic_sent = vol(1'b0, 5'h13);
        quiet("R7 no resend when unchanged", 20);
        // stray acknowledge in idle (R4)
        cmd_taken = 1'b1; @(negedge clk); cmd_taken = 1'b0;
        quiet("R4 stray ack in idle", 12);
        // R8: change while speaker command waits
        spk_mute = 1'b0; spk_att = 5'h1F;
        n = 0;
        while (!cmd_valid && n < 50) begin @(negedge clk); n++; end
        spk_mute = 1'b1; spk_att = 5'h01;
        repeat (8) @(negedge clk);
        serve("R8 old word first", 7'h02, vol(1'b0, 5'h1F));
        serve("R8 new word second", 7'h02, vol(1'b1, 5'h01));
        spk_sent = vol(1'b1, 5'h01);
        quiet("R8 no third", 12);
        // random rounds
        for (int r = 0; r < 30; r++) begin
            nm = spk_mute; na = spk_att; nmm = mic_mute; ng = mic_gain;
            if ($urandom_range(0, 1)) begin nm = 1'($urandom); na = ATT_W'($urandom); end
            if ($urandom_range(0, 1)) begin nmm = 1'($urandom); ng = ATT_W'($urandom); end
            spk_mute = nm; spk_att = na; mic_mute = nmm; mic_gain = ng;
            repeat (8) @(negedge clk);
            if (vol(nm, na) != spk_sent) begin
                serve("R7 speaker resend", 7'h02, vol(nm, na));
                spk_sent = vol(nm, na);
            end
            if (vol(nmm, ng) != mic_sent) begin
                serve("R7 mic resend", 7'h0E, vol(nmm, ng));
                mic_sent = vol(nmm, ng);
            end
            quiet("R7 quiet after round", 10);
        end
        // R7/R6: both change, speaker first; full-scale values
        spk_mute = ~spk_mute; spk_att = ~spk_att; mic_mute = ~mic_mute; mic_gain = ~mic_gain;
        repeat (8) @(negedge clk);
        serve("R7 both speaker first", 7'h02, vol(spk_mute, spk_att));
        serve("R6 both mic second", 7'h0E, vol(mic_mute, mic_gain));
        check("R9 pcm_en held", 32'(pcm_en), 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule